// File: doc/BRIEF.md
# Operand Address and Bit-Test Branch Unit

This unit sits beside an 8-bit core's instruction decoder. It takes an instruction that has already been decoded, along with the operand bytes, both index registers, the flags and one byte read from memory. From these it forms the effective operand address and the branch destination. It also decides whether a branch is taken and works out the byte that a mask-based set-bits or clear-bits operation writes back. Decode, the memory bus and the ALU live elsewhere. The unit only evaluates.

A one-cycle `start` strobe captures the inputs. One clock later the results appear in output registers, and `done` pulses for that cycle. The registers keep their values until the next strobe, so the sequencer can consume them over several cycles while it changes the inputs. The unit computes the address and the branch destination on every strobe. The sequencer selects which results it uses.

Top module: `ea_branch_unit`

## Requirements
- R1: With `addr_mode` = 0 (zero-page), `ea` equals `opnd0` zero-extended, so its upper byte is always 0x00.
- R2: With `addr_mode` = 1 (absolute), `ea` = `opnd0` × 256 + `opnd1`, with the first operand byte as the high byte. The unused code 3 gives `ea` = 0.
- R3: With `addr_mode` = 2 (indexed), `ea` = base + `opnd0`, where `opnd0` is taken as unsigned 0..255. The base is `idx_y` when `use_y` = 1 and `idx_x` otherwise. The sum wraps modulo 65536.
- R4: `target` = `next_pc` + `rel_off`, where `rel_off` is taken as signed −128..+127. The sum wraps modulo 65536.
- R5: When `op_kind` = 1 (flag branch), the branch is decided by `cond_sel`. Code 0 is always taken and code 1 is never taken. Codes 4/5 are taken on C = 0 and C = 1. Codes 6/7 are taken on Z = 0 and Z = 1. Codes 8/9 are taken on V = 0 and V = 1. Codes A/B are taken on N = 0 and N = 1. The flag bits are `flags[3]` = N, `flags[2]` = Z, `flags[1]` = V and `flags[0]` = C.
- R6: Code 2 (unsigned higher) is taken when C|Z = 0. Code 3 (lower or same) is taken when C|Z = 1.
- R7: The signed codes work on N^V. Code C is taken when N^V = 0 and code D when N^V = 1. Code E is taken when Z|(N^V) = 0 and code F when Z|(N^V) = 1.
- R8: `wr_data` depends on `op_kind`. With `op_kind` = 2 it is `mem_byte | bit_mask`. With `op_kind` = 3 it is `mem_byte & ~bit_mask`. With any other code it is `mem_byte` unchanged.
- R9: With `op_kind` = 4, the branch is taken when every bit selected by `bit_mask` is 1 in `mem_byte`. With `op_kind` = 5, it is taken when every selected bit is 0. A zero mask is always taken in both cases.
- R10: `taken` is 0 for `op_kind` codes 0, 2, 3, 6 and 7.
- R11: Results appear the cycle after `start` = 1, and `done` is high for exactly that cycle. When `start` = 0, `done` is 0 in the following cycle and all result outputs keep their values.
- R12: While `rst_n` is low, all outputs are 0. After `rst_n` rises, the unit ignores `start` for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe |
| addr_mode | input | 2 | 0 zero-page, 1 absolute, 2 indexed, 3 none |
| use_y | input | 1 | Indexed mode uses Y instead of X |
| opnd0 | input | 8 | First operand byte |
| opnd1 | input | 8 | Second operand byte (low address byte) |
| rel_off | input | 8 | Signed branch displacement |
| bit_mask | input | 8 | Bit-select mask |
| op_kind | input | 3 | 0 none, 1 flag branch, 2 set bits, 3 clear bits, 4 branch if bits set, 5 branch if bits clear |
| cond_sel | input | 4 | Flag-branch condition code |
| flags | input | 4 | {N, Z, V, C} |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| next_pc | input | 16 | Address following the displacement byte |
| mem_byte | input | 8 | Byte read from the operand address |
| ea | output | 16 | Effective address |
| target | output | 16 | Branch destination |
| taken | output | 1 | Branch decision |
| wr_data | output | 8 | Write-back byte for bit operations |
| done | output | 1 | Result-valid pulse |

## Verification
The bench builds the unit with its default widths: a 16-bit address and an 8-bit data path. With these widths, index sums and displacement sums can be driven across the 0xFFFF/0x0000 boundary. The full 8-bit mask space is also reachable, including the zero mask and the all-ones mask. Directed vectors cover every one of the sixteen condition codes under several flag combinations, and they cover every operation kind, including the unused codes. A long run of pseudo-random strobes, some with `start` held low, checks that results hold between strobes. A reset asserted in the middle of the run checks that the outputs clear.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    AM_ZPAGE = 2'd0,
    AM_ABS   = 2'd1,
    AM_INDEX = 2'd2,
    AM_NONE  = 2'd3
  } addr_mode_e;

  typedef enum logic [2:0] {
    OPK_NONE    = 3'd0,
    OPK_FLAGBR  = 3'd1,
    OPK_SETBITS = 3'd2,
    OPK_CLRBITS = 3'd3,
    OPK_BRSET   = 3'd4,
    OPK_BRCLR   = 3'd5
  } op_kind_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  addr_mode_e    mode,
  input  logic          use_y,
  input  logic [DW-1:0] opnd0,
  input  logic [DW-1:0] opnd1,
  input  logic [DW-1:0] rel_off,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic [AW-1:0] next_pc,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] target
);
  localparam int PAD_W = AW - DW;
  localparam int CAT_W = 2 * DW;

  logic [CAT_W-1:0] abs_cat;
  logic [AW-1:0]    abs_addr;
  logic [AW-1:0]    zp_addr;
  logic [AW-1:0]    base;
  logic [AW-1:0]    off_u;
  logic [AW-1:0]    off_s;

  assign abs_cat = {opnd0, opnd1};

  generate
    if (AW > CAT_W) begin : g_abs_pad
      assign abs_addr = {{(AW-CAT_W){1'b0}}, abs_cat};
    end else if (AW == CAT_W) begin : g_abs_exact
      assign abs_addr = abs_cat;
    end else begin : g_abs_trunc
      assign abs_addr = abs_cat[AW-1:0];
    end
  endgenerate

  assign zp_addr = {{PAD_W{1'b0}}, opnd0};
  assign base    = use_y ? idx_y : idx_x;
  assign off_u   = {{PAD_W{1'b0}}, opnd0};
  assign off_s   = {{PAD_W{rel_off[DW-1]}}, rel_off};

  always_comb begin
    unique case (mode)
      AM_ZPAGE: ea = zp_addr;
      AM_ABS:   ea = abs_addr;
      AM_INDEX: ea = base + off_u;
      default:  ea = '0;
    endcase
  end

  assign target = next_pc + off_s;

endmodule

// File: rtl/ea_cond_eval.sv
module ea_cond_eval
  import ea_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  logic [3:0] flags,
  output logic       cond_true
);
  logic n_f, z_f, v_f, c_f, nv;
  logic base_true;

  assign n_f = flags[FLAG_N];
  assign z_f = flags[FLAG_Z];
  assign v_f = flags[FLAG_V];
  assign c_f = flags[FLAG_C];
  assign nv  = n_f ^ v_f;

  // Codes come in complementary pairs: bit 0 inverts the base test.
  always_comb begin
    unique case (cond_sel[3:1])
      3'd0: base_true = 1'b1;
      3'd1: base_true = ~(c_f | z_f);
      3'd2: base_true = ~c_f;
      3'd3: base_true = ~z_f;
      3'd4: base_true = ~v_f;
      3'd5: base_true = ~n_f;
      3'd6: base_true = ~nv;
      default: base_true = ~(z_f | nv);
    endcase
  end

  assign cond_true = base_true ^ cond_sel[0];

endmodule

// File: rtl/ea_bitop.sv
module ea_bitop
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_kind_e      kind,
  input  logic [DW-1:0] mem_byte,
  input  logic [DW-1:0] bit_mask,
  output logic [DW-1:0] wr_val,
  output logic          all_set,
  output logic          all_clear
);
  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;
  logic [DW-1:0] miss_one;
  logic [DW-1:0] hit_one;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      assign set_v[i]    = mem_byte[i] | bit_mask[i];
      assign clr_v[i]    = mem_byte[i] & ~bit_mask[i];
      assign miss_one[i] = bit_mask[i] & ~mem_byte[i];
      assign hit_one[i]  = bit_mask[i] & mem_byte[i];
    end
  endgenerate

  assign all_set   = ~|miss_one;
  assign all_clear = ~|hit_one;

  always_comb begin
    unique case (kind)
      OPK_SETBITS: wr_val = set_v;
      OPK_CLRBITS: wr_val = clr_v;
      default:     wr_val = mem_byte;
    endcase
  end

endmodule

// File: rtl/ea_branch_unit.sv
module ea_branch_unit
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    addr_mode,
  input  logic          use_y,
  input  logic [DW-1:0] opnd0,
  input  logic [DW-1:0] opnd1,
  input  logic [DW-1:0] rel_off,
  input  logic [DW-1:0] bit_mask,
  input  logic [2:0]    op_kind,
  input  logic [3:0]    cond_sel,
  input  logic [3:0]    flags,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic [AW-1:0] next_pc,
  input  logic [DW-1:0] mem_byte,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] target,
  output logic          taken,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  addr_mode_e    mode_e;
  op_kind_e      kind_e;
  logic [1:0]    rst_pipe;
  logic          rst_int_n;

  logic [AW-1:0] ea_c, tgt_c;
  logic [DW-1:0] wr_c;
  logic          cond_c, all_set_c, all_clr_c;

  logic [AW-1:0] ea_q, ea_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [DW-1:0] wr_q, wr_d;
  logic          tk_q, tk_d;
  logic          done_q;
  logic          tk_c;

  assign mode_e = addr_mode_e'(addr_mode);
  assign kind_e = op_kind_e'(op_kind);

  // Reset asserts at once, leaves two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ea_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .mode    (mode_e),
    .use_y   (use_y),
    .opnd0   (opnd0),
    .opnd1   (opnd1),
    .rel_off (rel_off),
    .idx_x   (idx_x),
    .idx_y   (idx_y),
    .next_pc (next_pc),
    .ea      (ea_c),
    .target  (tgt_c)
  );

  ea_cond_eval u_cond (
    .cond_sel  (cond_sel),
    .flags     (flags),
    .cond_true (cond_c)
  );

  ea_bitop #(.DW(DW)) u_bits (
    .kind      (kind_e),
    .mem_byte  (mem_byte),
    .bit_mask  (bit_mask),
    .wr_val    (wr_c),
    .all_set   (all_set_c),
    .all_clear (all_clr_c)
  );

  always_comb begin
    unique case (kind_e)
      OPK_FLAGBR: tk_c = cond_c;
      OPK_BRSET:  tk_c = all_set_c;
      OPK_BRCLR:  tk_c = all_clr_c;
      default:    tk_c = 1'b0;
    endcase
  end

  // Next-state: load on start, hold otherwise.
  always_comb begin
    ea_d  = ea_q;
    tgt_d = tgt_q;
    wr_d  = wr_q;
    tk_d  = tk_q;
    if (start) begin
      ea_d  = ea_c;
      tgt_d = tgt_c;
      wr_d  = wr_c;
      tk_d  = tk_c;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ea_q   <= '0;
      tgt_q  <= '0;
      wr_q   <= '0;
      tk_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ea_q   <= ea_d;
      tgt_q  <= tgt_d;
      wr_q   <= wr_d;
      tk_q   <= tk_d;
      done_q <= start;
    end
  end

  assign ea      = ea_q;
  assign target  = tgt_q;
  assign taken   = tk_q;
  assign wr_data = wr_q;
  assign done    = done_q;

endmodule

// File: rtl/ea_branch_unit_chk.sv
module ea_branch_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    addr_mode,
  input logic [DW-1:0] opnd0,
  input logic [DW-1:0] bit_mask,
  input logic [2:0]    op_kind,
  input logic [3:0]    cond_sel,
  input logic [DW-1:0] mem_byte,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] target,
  input logic          taken,
  input logic [DW-1:0] wr_data,
  input logic          done
);

  assert_zpage_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && addr_mode == 2'd0) |=> (ea[AW-1:DW] == '0 && ea[DW-1:0] == $past(opnd0)));

  assert_setbits_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == 3'd2) |=> (wr_data == ($past(mem_byte) | $past(bit_mask))));

  assert_clrbits_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == 3'd3) |=> (wr_data == ($past(mem_byte) & ~$past(bit_mask))));

  assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == 3'd1 && cond_sel == 4'h0) |=> taken);

  assert_never_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == 3'd1 && cond_sel == 4'h1) |=> !taken);

  assert_zero_mask_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_kind == 3'd4 || op_kind == 3'd5) && bit_mask == '0) |=> taken);

  assert_nonbranch_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_kind == 3'd0 || op_kind == 3'd2 || op_kind == 3'd3 ||
               op_kind == 3'd6 || op_kind == 3'd7)) |=> !taken);

  assert_done_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_no_done_without_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(ea) && $stable(target) && $stable(taken) && $stable(wr_data)));

endmodule

bind ea_branch_unit ea_branch_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .addr_mode (addr_mode),
  .opnd0     (opnd0),
  .bit_mask  (bit_mask),
  .op_kind   (op_kind),
  .cond_sel  (cond_sel),
  .mem_byte  (mem_byte),
  .ea        (ea),
  .target    (target),
  .taken     (taken),
  .wr_data   (wr_data),
  .done      (done)
);

// File: tb/ea_branch_unit_tb.sv
module ea_branch_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  addr_mode;
  logic        use_y;
  logic [7:0]  opnd0, opnd1, rel_off, bit_mask, mem_byte;
  logic [2:0]  op_kind;
  logic [3:0]  cond_sel, flags;
  logic [15:0] idx_x, idx_y, next_pc;
  logic [15:0] ea, target;
  logic        taken, done;
  logic [7:0]  wr_data;

  int checks;
  int fails;
  int cyc;
  bit finished;

  // Reference model state.
  int    m_ea, m_tgt, m_wr;
  bit    m_tk, m_done;
  string t_ea, t_tk;

  ea_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_mode(addr_mode), .use_y(use_y),
    .opnd0(opnd0), .opnd1(opnd1), .rel_off(rel_off), .bit_mask(bit_mask),
    .op_kind(op_kind), .cond_sel(cond_sel), .flags(flags), .idx_x(idx_x),
    .idx_y(idx_y), .next_pc(next_pc), .mem_byte(mem_byte), .ea(ea),
    .target(target), .taken(taken), .wr_data(wr_data), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit ref_cond(input int cs, input int fl);
    bit n, z, v, c;
    n = fl[3]; z = fl[2]; v = fl[1]; c = fl[0];
    case (cs)
      0:  return 1;
      1:  return 0;
      2:  return (c == 0 && z == 0);
      3:  return (c == 1 || z == 1);
      4:  return c == 0;
      5:  return c == 1;
      6:  return z == 0;
      7:  return z == 1;
      8:  return v == 0;
      9:  return v == 1;
      10: return n == 0;
      11: return n == 1;
      12: return n == v;
      13: return n != v;
      14: return (z == 0 && n == v);
      default: return (z == 1 || n != v);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ea <= 0; m_tgt <= 0; m_wr <= 0; m_tk <= 0; m_done <= 0;
      t_ea <= "R12"; t_tk <= "R12";
    end else begin
      m_done <= start;
      if (start) begin
        int e, r, w;
        bit k;
        case (addr_mode)
          2'd0: begin e = opnd0; t_ea <= "R1"; end
          2'd1: begin e = opnd0 * 256 + opnd1; t_ea <= "R2"; end
          2'd2: begin e = ((use_y ? idx_y : idx_x) + opnd0) % 65536; t_ea <= "R3"; end
          default: begin e = 0; t_ea <= "R2"; end
        endcase
        r = (rel_off >= 128) ? int'(rel_off) - 256 : int'(rel_off);
        m_tgt <= (int'(next_pc) + r + 65536) % 65536;
        w = mem_byte;
        if (op_kind == 3'd2) w = mem_byte | bit_mask;
        if (op_kind == 3'd3) w = mem_byte & (~bit_mask);
        k = 0;
        case (op_kind)
          3'd1: begin
            k = ref_cond(cond_sel, flags);
            if (cond_sel == 2 || cond_sel == 3) t_tk <= "R6";
            else if (cond_sel >= 12) t_tk <= "R7";
            else t_tk <= "R5";
          end
          3'd4: begin k = ((mem_byte & bit_mask) == bit_mask); t_tk <= "R9"; end
          3'd5: begin k = ((mem_byte & bit_mask) == 0); t_tk <= "R9"; end
          default: begin k = 0; t_tk <= "R10"; end
        endcase
        m_ea <= e; m_wr <= w; m_tk <= k;
      end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    string hold;
    hold = m_done ? "" : "R11";
    cmp(hold == "" ? t_ea : hold, "ea", ea, m_ea);
    cmp(hold == "" ? "R4" : hold, "target", target, m_tgt);
    cmp(hold == "" ? t_tk : hold, "taken", taken, m_tk);
    cmp(hold == "" ? "R8" : hold, "wr_data", wr_data, m_wr);
    cmp("R11", "done", done, m_done);
  endtask

  task automatic drive(input bit st, input logic [1:0] am, input bit uy,
                       input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] rl,
                       input logic [7:0] mk, input logic [2:0] ok, input logic [3:0] cs,
                       input logic [3:0] fl, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] pc, input logic [7:0] mb);
    start = st; addr_mode = am; use_y = uy; opnd0 = o0; opnd1 = o1; rel_off = rl;
    bit_mask = mk; op_kind = ok; cond_sel = cs; flags = fl; idx_x = x; idx_y = y;
    next_pc = pc; mem_byte = mb;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      start = 1'b0;
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; finished = 0;
    rst_n = 1'b0;
    start = 0; addr_mode = 0; use_y = 0; opnd0 = 0; opnd1 = 0; rel_off = 0;
    bit_mask = 0; op_kind = 0; cond_sel = 0; flags = 0; idx_x = 0; idx_y = 0;
    next_pc = 0; mem_byte = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    cmp("R12", "ea", ea, 0);
    cmp("R12", "taken", taken, 0);
    cmp("R12", "done", done, 0);
    rst_n = 1'b1;
    idle(4);

    // R1 zero-page
    drive(1, 2'd0, 0, 8'hA5, 8'h77, 8'h00, 8'h00, 3'd0, 4'h0, 4'h0, 16'h1234, 16'h5678, 16'h0100, 8'h3C);
    // R2 absolute, and unused code
    drive(1, 2'd1, 0, 8'h12, 8'h34, 8'h10, 8'h00, 3'd0, 4'h0, 4'h0, 16'h0, 16'h0, 16'h2000, 8'h00);
    drive(1, 2'd3, 0, 8'h12, 8'h34, 8'h10, 8'h00, 3'd6, 4'h0, 4'h0, 16'h0, 16'h0, 16'h2000, 8'h00);
    // R3 indexed X, Y with wrap
    drive(1, 2'd2, 0, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd0, 4'h0, 4'h0, 16'h1000, 16'hFFF0, 16'h0, 8'h00);
    drive(1, 2'd2, 1, 8'h20, 8'h00, 8'h00, 8'h00, 3'd0, 4'h0, 4'h0, 16'h1000, 16'hFFF0, 16'h0, 8'h00);
    // R4 displacement extremes with wrap both ways
    drive(1, 2'd0, 0, 8'h00, 8'h00, 8'h80, 8'h00, 3'd1, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0005, 8'h00);
    drive(1, 2'd0, 0, 8'h00, 8'h00, 8'h7F, 8'h00, 3'd1, 4'h1, 4'h0, 16'h0, 16'h0, 16'hFFF0, 8'h00);
    // R5 R6 R7 every condition code under several flag sets
    for (int f = 0; f < 16; f += 5) begin
      for (int c = 0; c < 16; c++) begin
        drive(1, 2'd0, 0, 8'h00, 8'h00, 8'h02, 8'h00, 3'd1, 4'(c), 4'(f), 16'h0, 16'h0, 16'h0400, 8'h00);
      end
    end
    // R8 set/clear bits and pass-through
    drive(1, 2'd0, 0, 8'h40, 8'h00, 8'h00, 8'hF0, 3'd2, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'h0F);
    drive(1, 2'd0, 0, 8'h40, 8'h00, 8'h00, 8'h81, 3'd3, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hFF);
    drive(1, 2'd0, 0, 8'h40, 8'h00, 8'h00, 8'hFF, 3'd4, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'h5A);
    // R9 bit-test branches including zero mask
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h00, 3'd4, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'h00);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h00, 3'd5, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hFF);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h30, 3'd4, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hF0);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h31, 3'd4, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hF0);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h0F, 3'd5, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hF0);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h1F, 3'd5, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 8'hF0);
    // R10 codes without a branch, with flags that would satisfy anything
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h00, 3'd7, 4'h0, 4'hF, 16'h0, 16'h0, 16'h0, 8'hFF);
    drive(1, 2'd0, 0, 8'h10, 8'h00, 8'h04, 8'h00, 3'd0, 4'h0, 4'hF, 16'h0, 16'h0, 16'h0, 8'hFF);
    // R11 hold while start is low and inputs move
    drive(1, 2'd1, 0, 8'hBE, 8'hEF, 8'h10, 8'h0F, 3'd2, 4'h0, 4'h0, 16'h0, 16'h0, 16'h3000, 8'h30);
    drive(0, 2'd2, 1, 8'h01, 8'h02, 8'h90, 8'hFF, 3'd3, 4'h0, 4'h0, 16'h1, 16'h2, 16'h0, 8'hFF);
    drive(0, 2'd0, 0, 8'h77, 8'h66, 8'h55, 8'h00, 3'd1, 4'h0, 4'h0, 16'h9, 16'h8, 16'h7, 8'h00);

    // Pseudo-random vectors
    for (int i = 0; i < 3000; i++) begin
      int r0, r1, r2;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      drive((r0 % 4) != 0, 2'(r0 >> 4), r0[6], 8'(r1), 8'(r1 >> 8), 8'(r1 >> 16),
            8'(r1 >> 24), 3'(r0 >> 8), 4'(r0 >> 12), 4'(r0 >> 16), 16'(r2),
            16'(r2 >> 16), 16'(r0 >> 12), 8'(r0 >> 20));
      if (i == 1500) begin
        // R12: reset asserted in mid-run clears outputs
        rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        cmp("R12", "ea", ea, 0);
        cmp("R12", "wr_data", wr_data, 0);
        cmp("R12", "target", target, 0);
        rst_n = 1'b1;
        idle(4);
      end
    end
    idle(2);
    summary();
  end

endmodule